// File: doc/BRIEF.md
# Histogram Readout Control Registers

This block is the software-facing control point for copying one histogram out of a bank of parallel histogram instances. A small register file on the management clock holds the number of the instance to copy and accepts a fill command. The command is carried into the data-path clock domain as a single-cycle request for the copy engine. That engine, the histogram counters and the readout memory are outside this block. The engine reports its progress through a filling flag, and the histogram bank reports page zeroing through a clearing flag. Both flags come from instance 0, are resynchronised to the management clock, and can be read back over the bus.

Software selects an instance and then issues the fill command. It polls the fill status until the status reads zero, and only then reads the readout memory. The fill status reads one from the moment the command is accepted, so a poll issued straight after the command cannot wrongly see the copy as finished. While a fill is in progress, the instance number cannot change and further fill commands are dropped.

Register map: address 0 bit 0 holds the clearing flag (read only). Address 1 holds the instance select (read/write). Address 2 bit 0 starts a fill when written and returns the fill status when read.

Top module: `hist_rdout_regs`

## Requirements
- R1: After reset, the instance select is 0. No read data is valid, read data is all zero, and no fill request has been issued.
- R2: Every cycle with `bus_rd` high is followed one management cycle later by `bus_rvalid` high, carrying the data for that address. `bus_rvalid` is low in the cycle after any cycle without a read.
- R3: A write to address 1 with a value from 0 to N_INST-1 updates the instance select. The new value drives `inst_sel` and is returned by reads of address 1 in bits SEL_W-1:0.
- R4: A write to address 1 with a value of N_INST or more, judged on the full write word, leaves the instance select unchanged.
- R5: A write to address 2 with bit 0 set produces exactly one single-cycle `dp_fill_req` pulse on the data-path clock. A write to address 2 with bit 0 clear produces none.
- R6: A read of address 2 returns the fill status in bit 0. The status is 1 from the cycle after an accepted fill command until the synchronised `dp_filling` has been seen high and then has fallen. Afterwards it reads 0.
- R7: A read of address 0 returns `dp_clearing`, after two management-clock synchroniser stages, in bit 0.
- R8: While the fill status is 1, writes to address 1 and fill commands to address 2 are ignored. `inst_sel` stays stable and no extra `dp_fill_req` pulse is produced.
- R9: Unused bits of mapped registers read as zero. Addresses 3 and above read as zero, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mm_clk | input | 1 | Management (bus) clock |
| mm_rst | input | 1 | Asynchronous active-high reset, management domain |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after bus_rd |
| inst_sel | output | SEL_W | Selected histogram instance for the copy engine |
| dp_clk | input | 1 | Data-path clock |
| dp_rst | input | 1 | Asynchronous active-high reset, data-path domain |
| dp_filling | input | 1 | Copy-in-progress flag from instance 0 |
| dp_clearing | input | 1 | Page-zeroing flag from instance 0 |
| dp_fill_req | output | 1 | Single-cycle fill request on the data-path clock |

## Verification
The hardest condition to reach is a register write that arrives while a fill is still in progress. It needs the data-path flag to be high and to have passed through the synchroniser before the write arrives. The bench reaches this condition in two ways. In the first, it forces the filling flag high from the data-path side and waits well beyond the synchroniser depth. In the second, a copy-engine model raises the flag for a fixed number of data-path cycles after each request, and the bench issues a second fill command straight after the first. The number of requests is counted on the data-path side, so a lost or duplicated crossing shows up as a wrong count. The bench does not rely on a particular arrival cycle.

// File: rtl/hist_rdout_pkg.sv
`timescale 1ns/1ps
package hist_rdout_pkg;
    // Register addresses; software and the copy flow depend on these values.
    localparam int unsigned REG_CLEAR = 0;
    localparam int unsigned REG_SEL   = 1;
    localparam int unsigned REG_FILL  = 2;
endpackage

// File: rtl/hist_sync2.sv
`timescale 1ns/1ps
module hist_sync2 #(
    parameter int unsigned W = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;
    logic [W-1:0] stab_q;

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            meta_q <= '0;
            stab_q <= '0;
        end else begin
            meta_q <= d;
            stab_q <= meta_q;
        end
    end

    assign q = stab_q;
endmodule

// File: rtl/hist_pulse_xfer.sv
`timescale 1ns/1ps
module hist_pulse_xfer (
    input  logic src_clk,
    input  logic src_rst,
    input  logic src_pulse,
    input  logic dst_clk,
    input  logic dst_rst,
    output logic dst_pulse
);
    logic tgl_q;
    logic tgl_d;
    logic tgl_s;
    logic seen_q;

    // Source side: each request flips a level.
    always_comb tgl_d = src_pulse ? ~tgl_q : tgl_q;

    always_ff @(posedge src_clk or posedge src_rst) begin
        if (src_rst) tgl_q <= 1'b0;
        else         tgl_q <= tgl_d;
    end

    hist_sync2 #(.W(1)) u_tgl_sync (
        .clk (dst_clk),
        .rst (dst_rst),
        .d   (tgl_q),
        .q   (tgl_s)
    );

    // Destination side: any level change is one request.
    always_ff @(posedge dst_clk or posedge dst_rst) begin
        if (dst_rst) seen_q <= 1'b0;
        else         seen_q <= tgl_s;
    end

    assign dst_pulse = tgl_s ^ seen_q;
endmodule

// File: rtl/hist_rdout_regs.sv
`timescale 1ns/1ps
module hist_rdout_regs
    import hist_rdout_pkg::*;
#(
    parameter int unsigned N_INST = 12,
    parameter int unsigned ADDR_W = 4,
    parameter int unsigned DATA_W = 32,
    localparam int unsigned SEL_W = (N_INST > 1) ? $clog2(N_INST) : 1
) (
    input  logic              mm_clk,
    input  logic              mm_rst,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_rvalid,
    output logic [SEL_W-1:0]  inst_sel,
    input  logic              dp_clk,
    input  logic              dp_rst,
    input  logic              dp_filling,
    input  logic              dp_clearing,
    output logic              dp_fill_req
);
    localparam logic [ADDR_W-1:0] A_CLEAR = ADDR_W'(REG_CLEAR);
    localparam logic [ADDR_W-1:0] A_SEL   = ADDR_W'(REG_SEL);
    localparam logic [ADDR_W-1:0] A_FILL  = ADDR_W'(REG_FILL);
    localparam logic [DATA_W-1:0] SEL_LIM = DATA_W'(N_INST);

    typedef struct packed {
        logic [SEL_W-1:0]  sel;
        logic              pend;
        logic [DATA_W-1:0] rdata;
        logic              rvalid;
    } mm_regs_t;

    mm_regs_t r_q;
    mm_regs_t r_d;

    logic fill_s;
    logic clear_s;
    logic busy;
    logic fill_go;

    // Status flags from instance 0 into the management domain.
    hist_sync2 #(.W(2)) u_stat_sync (
        .clk (mm_clk),
        .rst (mm_rst),
        .d   ({dp_filling, dp_clearing}),
        .q   ({fill_s, clear_s})
    );

    assign busy = r_q.pend | fill_s;

    always_comb begin
        r_d        = r_q;
        fill_go    = 1'b0;
        r_d.rvalid = bus_rd;
        r_d.rdata  = '0;

        // Pending bit hands over to the synchronised flag once seen.
        if (fill_s) r_d.pend = 1'b0;

        if (bus_wr && !busy) begin
            case (bus_addr)
                A_SEL: begin
                    if (bus_wdata < SEL_LIM) r_d.sel = bus_wdata[SEL_W-1:0];
                end
                A_FILL: begin
                    if (bus_wdata[0]) begin
                        fill_go  = 1'b1;
                        r_d.pend = 1'b1;
                    end
                end
                default: ;
            endcase
        end

        if (bus_rd) begin
            case (bus_addr)
                A_CLEAR: r_d.rdata[0]         = clear_s;
                A_SEL:   r_d.rdata[SEL_W-1:0] = r_q.sel;
                A_FILL:  r_d.rdata[0]         = busy;
                default: ;
            endcase
        end
    end

    always_ff @(posedge mm_clk or posedge mm_rst) begin
        if (mm_rst) r_q <= '0;
        else        r_q <= r_d;
    end

    hist_pulse_xfer u_fill_xfer (
        .src_clk   (mm_clk),
        .src_rst   (mm_rst),
        .src_pulse (fill_go),
        .dst_clk   (dp_clk),
        .dst_rst   (dp_rst),
        .dst_pulse (dp_fill_req)
    );

    assign bus_rdata  = r_q.rdata;
    assign bus_rvalid = r_q.rvalid;
    assign inst_sel   = r_q.sel;
endmodule

// File: rtl/hist_rdout_chk.sv
`timescale 1ns/1ps
module hist_rdout_chk #(
    parameter int unsigned N_INST = 12,
    parameter int unsigned ADDR_W = 4,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned SEL_W  = 4
) (
    input logic              mm_clk,
    input logic              mm_rst,
    input logic              dp_clk,
    input logic              dp_rst,
    input logic              bus_rd,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              bus_rvalid,
    input logic [SEL_W-1:0]  inst_sel,
    input logic              busy,
    input logic              dp_fill_req
);
    // R2
    rvalid_after_rd_chk: assert property (@(posedge mm_clk) disable iff (mm_rst)
        bus_rd |=> bus_rvalid);

    // R2
    rvalid_only_rd_chk: assert property (@(posedge mm_clk) disable iff (mm_rst)
        !bus_rd |=> !bus_rvalid);

    // R9
    unmapped_zero_chk: assert property (@(posedge mm_clk) disable iff (mm_rst)
        (bus_rd && (bus_addr > ADDR_W'(2))) |=> (bus_rdata == '0));

    // R3
    sel_readback_chk: assert property (@(posedge mm_clk) disable iff (mm_rst)
        (bus_rd && (bus_addr == ADDR_W'(1))) |=> (bus_rdata == DATA_W'($past(inst_sel))));

    // R4
    sel_in_range_chk: assert property (@(posedge mm_clk) disable iff (mm_rst)
        ({1'b0, inst_sel} < (SEL_W+1)'(N_INST)));

    // R8
    sel_locked_chk: assert property (@(posedge mm_clk) disable iff (mm_rst)
        busy |=> $stable(inst_sel));

    // R5
    fill_req_single_chk: assert property (@(posedge dp_clk) disable iff (dp_rst)
        dp_fill_req |=> !dp_fill_req);
endmodule

bind hist_rdout_regs hist_rdout_chk #(
    .N_INST (N_INST),
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .SEL_W  (SEL_W)
) u_chk (
    .mm_clk      (mm_clk),
    .mm_rst      (mm_rst),
    .dp_clk      (dp_clk),
    .dp_rst      (dp_rst),
    .bus_rd      (bus_rd),
    .bus_addr    (bus_addr),
    .bus_rdata   (bus_rdata),
    .bus_rvalid  (bus_rvalid),
    .inst_sel    (inst_sel),
    .busy        (busy),
    .dp_fill_req (dp_fill_req)
);

// File: tb/sim_hist_rdout_regs.sv
`timescale 1ns/1ps
module sim_hist_rdout_regs;
    localparam int unsigned N_INST = 12;
    localparam int unsigned ADDR_W = 4;
    localparam int unsigned DATA_W = 32;
    localparam int unsigned SEL_W  = 4;
    localparam int unsigned ENG_LEN = 20;

    logic mm_clk = 1'b0;
    logic dp_clk = 1'b0;
    logic mm_rst = 1'b1;
    logic dp_rst = 1'b1;
    logic bus_wr = 1'b0;
    logic bus_rd = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [DATA_W-1:0] bus_wdata = '0;
    logic [DATA_W-1:0] bus_rdata;
    logic bus_rvalid;
    logic [SEL_W-1:0] inst_sel;
    logic dp_fill_req;
    logic dp_clearing = 1'b0;
    logic man_filling = 1'b0;
    logic eng_filling = 1'b0;
    logic eng_auto = 1'b0;
    logic dp_filling;
    int   eng_left = 0;
    int   pulse_cnt = 0;
    int   n_chk = 0;
    int   n_err = 0;

    assign dp_filling = eng_filling | man_filling;

    always #2 mm_clk = ~mm_clk;   // 250 MHz
    always #3 dp_clk = ~dp_clk;

    hist_rdout_regs #(.N_INST(N_INST), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u0 (
        .mm_clk(mm_clk), .mm_rst(mm_rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_rvalid(bus_rvalid), .inst_sel(inst_sel), .dp_clk(dp_clk),
        .dp_rst(dp_rst), .dp_filling(dp_filling), .dp_clearing(dp_clearing),
        .dp_fill_req(dp_fill_req)
    );

    // Copy-engine model: counts requests, optionally raises filling.
    always @(negedge dp_clk) begin
        if (dp_fill_req) begin
            pulse_cnt = pulse_cnt + 1;
            if (eng_auto) eng_left = ENG_LEN;
        end else if (eng_left > 0) begin
            eng_left = eng_left - 1;
        end
        eng_filling = (eng_left != 0);
    end

    typedef struct packed {
        logic              rd;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic [DATA_W-1:0] exp;
        logic [3:0]        req;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 4'd1,  32'd5,          32'd0,  4'd3},  // R3 select 5
        '{1'b1, 4'd1,  32'd0,          32'd5,  4'd3},
        '{1'b0, 4'd1,  32'd11,         32'd0,  4'd3},  // R3 top of range
        '{1'b1, 4'd1,  32'd0,          32'd11, 4'd3},
        '{1'b0, 4'd1,  32'd12,         32'd0,  4'd4},  // R4 one past range
        '{1'b1, 4'd1,  32'd0,          32'd11, 4'd4},
        '{1'b0, 4'd1,  32'h8000_0001,  32'd0,  4'd4},  // R4 high bits set
        '{1'b1, 4'd1,  32'd0,          32'd11, 4'd4},
        '{1'b0, 4'd1,  32'd3,          32'd0,  4'd3},
        '{1'b1, 4'd1,  32'd0,          32'd3,  4'd3},
        '{1'b1, 4'd3,  32'd0,          32'd0,  4'd9},  // R9 unmapped
        '{1'b0, 4'd3,  32'hFFFF_FFFF,  32'd0,  4'd9},
        '{1'b1, 4'd3,  32'd0,          32'd0,  4'd9},
        '{1'b1, 4'd15, 32'd0,          32'd0,  4'd9},
        '{1'b1, 4'd0,  32'd0,          32'd0,  4'd7},  // R7 idle clearing
        '{1'b1, 4'd2,  32'd0,          32'd0,  4'd6}   // R6 idle fill status
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk = n_chk + 1;
        if (act !== exp) begin
            n_err = n_err + 1;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
        @(negedge mm_clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge mm_clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic bus_read(input logic [ADDR_W-1:0] a, output logic [DATA_W-1:0] d, output logic v);
        @(negedge mm_clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge mm_clk);
        bus_rd = 1'b0;
        d = bus_rdata; v = bus_rvalid;
    endtask

    task automatic mm_wait(input int n);
        for (int i = 0; i < n; i++) @(negedge mm_clk);
    endtask

    initial begin
        #800000;
        n_err = n_err + 1;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        logic [DATA_W-1:0] rd;
        logic v;
        int   base;
        int   polls;
        logic saw_high;

        mm_wait(5);
        mm_rst = 1'b0;
        dp_rst = 1'b0;
        mm_wait(3);

        // R1 reset state
        check("R1 rvalid", {31'd0, bus_rvalid}, 32'd0);
        check("R1 rdata", bus_rdata, 32'd0);
        check("R1 inst_sel", 32'(inst_sel), 32'd0);
        check("R1 fill pulses", 32'(pulse_cnt), 32'd0);
        bus_read(4'd1, rd, v);
        check("R1 select read", rd, 32'd0);

        // R2 strobe timing
        check("R2 rvalid with data", {31'd0, v}, 32'd1);
        @(negedge mm_clk);
        check("R2 rvalid drops", {31'd0, bus_rvalid}, 32'd0);

        // Table walk: R3 R4 R6 R7 R9
        for (int i = 0; i < NV; i++) begin
            if (VECS[i].rd) begin
                bus_read(VECS[i].addr, rd, v);
                check($sformatf("R%0d row %0d", VECS[i].req, i), rd, VECS[i].exp);
            end else begin
                bus_write(VECS[i].addr, VECS[i].data);
            end
        end
        check("R3 inst_sel port", 32'(inst_sel), 32'd3);

        // R5 fill with bit 0 clear: no request
        bus_write(4'd2, 32'hFFFF_FFFE);
        mm_wait(20);
        check("R5 no pulse on bit0 clear", 32'(pulse_cnt), 32'd0);

        // R5 R6 normal fill with engine model
        eng_auto = 1'b1;
        bus_write(4'd2, 32'd1);
        bus_read(4'd2, rd, v);
        check("R6 status right after command", rd, 32'd1);
        saw_high = 1'b0;
        polls = 0;
        rd = 32'd1;
        while (rd[0] && polls < 200) begin
            bus_read(4'd2, rd, v);
            if (dp_filling) saw_high = 1'b1;
            polls++;
        end
        check("R6 status returns to zero", rd, 32'd0);
        check("R6 engine ran before status cleared", {31'd0, saw_high}, 32'd1);
        check("R5 exactly one pulse", 32'(pulse_cnt), 32'd1);

        // R8 second command while busy is dropped
        base = pulse_cnt;
        bus_write(4'd2, 32'd1);
        bus_write(4'd2, 32'd1);
        mm_wait(80);
        check("R8 busy fill command dropped", 32'(pulse_cnt), 32'(base + 1));

        // R8 select write during forced filling
        eng_auto = 1'b0;
        @(negedge dp_clk) man_filling = 1'b1;
        mm_wait(10);
        bus_write(4'd1, 32'd7);
        bus_read(4'd1, rd, v);
        check("R8 select held while busy", rd, 32'd3);
        check("R8 inst_sel held", 32'(inst_sel), 32'd3);
        base = pulse_cnt;
        bus_write(4'd2, 32'd1);
        mm_wait(20);
        check("R8 no pulse while busy", 32'(pulse_cnt), 32'(base));
        @(negedge dp_clk) man_filling = 1'b0;
        mm_wait(10);
        bus_write(4'd1, 32'd7);
        bus_read(4'd1, rd, v);
        check("R3 select after busy ends", rd, 32'd7);

        // R7 clearing flag, R9 isolation
        @(negedge dp_clk) dp_clearing = 1'b1;
        mm_wait(10);
        bus_read(4'd0, rd, v);
        check("R7 clearing high", rd, 32'd1);
        bus_read(4'd2, rd, v);
        check("R9 fill status unaffected by clearing", rd, 32'd0);
        @(negedge dp_clk) dp_clearing = 1'b0;
        mm_wait(10);
        bus_read(4'd0, rd, v);
        check("R7 clearing low", rd, 32'd0);

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule